// File: doc/BRIEF.md
# Variable Block Size SAD Merger

This block sits behind a 16x16 array of pixel-difference processing elements in a motion estimator. For every candidate search position the array delivers sixteen 4x4 sub-block SADs, together with the candidate motion vector. The merger adds these sub-block SADs in a shared adder tree. The tree builds the SAD of every partition of the macroblock, across all seven shapes, at the same time. A bank of 41 minimum trackers keeps, for each partition, the smallest SAD seen during the pass and the vector that produced it.

A pass begins with a `start` pulse. Candidates follow, one per clock and without gaps, with `in_last` set on the final one. A full search over a window of -32..+31 on each axis is 4096 candidates in raster order. The tree and the trackers are pipelined. Each candidate vector travels through the pipeline alongside its sums. `done` pulses once the last candidate has been folded into the trackers, and the 41 results are then stable on the outputs.

Partition index order, used on all result buses:
- 0: 16x16.
- 1-2: 16x8, top then bottom.
- 3-4: 8x16, left then right.
- 5-8: 8x8 quadrants, raster order.
- 9-16: 8x4, index 9+2q+h, where q is the quadrant and h selects the upper (0) or lower (1) half.
- 17-24: 4x8, index 17+2q+v, where v selects the left (0) or right (1) half.
- 25-40: 4x4, raster order.

Input sub-block k = 4*row + col occupies `in_sad4[12k+11:12k]`. Partition p occupies `best_sad[16p+15:16p]`, `best_mvx[6p+5:6p]` and `best_mvy[6p+5:6p]`.

Top module: `vbs_sad_merge`

## Requirements
- R1: After reset `done` is 0 and every `best_sad`, `best_mvx` and `best_mvy` field is 0.
- R2: Partition 0 reports the minimum, over the pass, of the sum of all sixteen sub-block SADs, with that candidate's vector. The sum is 16 bits and reaches 65520 with all inputs at 4095 without wrapping.
- R3: Partitions 1-4 report the minima of the 16x8 (sub-block rows 0-1 and 2-3) and 8x16 (sub-block columns 0-1 and 2-3) sums, with their vectors.
- R4: Partitions 5-8 report the minima of the four 2x2 sub-block quadrant sums, with their vectors.
- R5: Partitions 9-16 report the minima of sums of horizontally adjacent sub-block pairs inside each quadrant. Partitions 17-24 report the minima of sums of vertically adjacent pairs. Both follow the index order given above.
- R6: Partitions 25-40 report the minimum of each single sub-block SAD, with its vector.
- R7: After the first candidate, a tracker takes a new candidate only when its SAD is strictly smaller than the one held. On a tie the earlier candidate's vector is kept.
- R8: The first valid candidate after `start` loads every tracker without comparison, even when its SADs are larger than the results of the previous pass.
- R9: A candidate is accepted on every clock in which `in_valid` is 1, with no stall. A continuous 4096-candidate raster pass gives exact results.
- R10: `done` is high for exactly one clock. It is high in the cycle that follows the fourth rising edge counted from the edge that sampled the candidate carrying `in_last`. The results are final in that cycle.
- R11: Vectors are 6-bit two's complement per axis and are reported exactly as supplied with the winning candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new pass; the next accepted candidate is the first |
| in_valid | input | 1 | Candidate present this cycle |
| in_last | input | 1 | Marks the final candidate of the pass |
| in_mvx | input | 6 | Candidate horizontal vector, two's complement |
| in_mvy | input | 6 | Candidate vertical vector, two's complement |
| in_sad4 | input | 192 | Sixteen 12-bit sub-block SADs, sub-block k at bits 12k+11:12k |
| done | output | 1 | One-cycle pulse: results of the pass are final |
| best_sad | output | 656 | 41 minimum SADs, 16 bits each |
| best_mvx | output | 246 | 41 winning horizontal vectors, 6 bits each |
| best_mvy | output | 246 | 41 winning vertical vectors, 6 bits each |

## Verification
The hardest situation to reach from the ports is a tie on a running minimum. With full-range random SADs, two candidates almost never give equal sums for the same partition, so the strict-compare rule would go untested. The stimulus therefore includes a pass of constant SADs and a pass with SADs drawn from 0..3, where equal sums recur across all 41 partitions. A short pass of maximum SADs follows a pass of small ones. It shows that the first candidate overrides the older, smaller results and that the widest sum does not wrap.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int NBLK    = 16;
  localparam int NPART   = 41;
  localparam int P_FULL  = 0;
  localparam int P_HALFH = 1;
  localparam int P_HALFV = 3;
  localparam int P_QUAD  = 5;
  localparam int P_8X4   = 9;
  localparam int P_4X8   = 17;
  localparam int P_4X4   = 25;

  // index of the top-left sub-block of quadrant q in the 4x4 sub-block grid
  function automatic int quad_corner(input int q);
    return (q / 2) * 8 + (q % 2) * 2;
  endfunction

  // zero-extending add at the sum width
  function automatic logic [15:0] add16(input logic [15:0] a, input logic [15:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/vbs_tree.sv
module vbs_tree
  import vbs_pkg::*;
#(
  parameter int SAD4_W = 12,
  parameter int MV_W   = 6,
  parameter int SUM_W  = SAD4_W + 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic [MV_W-1:0]          in_mvx,
  input  logic [MV_W-1:0]          in_mvy,
  input  logic [NBLK*SAD4_W-1:0]   in_sad4,
  output logic                     out_valid,
  output logic                     out_first,
  output logic                     out_last,
  output logic [MV_W-1:0]          out_mvx,
  output logic [MV_W-1:0]          out_mvy,
  output logic [NPART*SUM_W-1:0]   out_sum
);
  localparam int PAD = SUM_W - SAD4_W;

  // stage 1: captured sub-block SADs, widened
  logic             s1_v, s1_f, s1_l;
  logic [MV_W-1:0]  s1_mx, s1_my;
  logic [SUM_W-1:0] s1_blk [NBLK];

  // stage 2: pairs and quadrants
  logic             s2_v, s2_f, s2_l;
  logic [MV_W-1:0]  s2_mx, s2_my;
  logic [SUM_W-1:0] s2_blk [NBLK];
  logic [SUM_W-1:0] s2_84 [8];
  logic [SUM_W-1:0] s2_48 [8];
  logic [SUM_W-1:0] s2_88 [4];
  logic [SUM_W-1:0] c_84 [8];
  logic [SUM_W-1:0] c_48 [8];
  logic [SUM_W-1:0] c_88 [4];

  // stage 3: all 41 partitions
  logic             s3_v, s3_f, s3_l;
  logic [MV_W-1:0]  s3_mx, s3_my;
  logic [SUM_W-1:0] s3_sum [NPART];
  logic [SUM_W-1:0] c_top, c_bot, c_lft, c_rgt, c_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_f <= 1'b0; s1_l <= 1'b0;
      s1_mx <= '0; s1_my <= '0;
      for (int k = 0; k < NBLK; k++) s1_blk[k] <= '0;
    end else begin
      s1_v  <= in_valid;
      s1_f  <= in_valid & in_first;
      s1_l  <= in_valid & in_last;
      s1_mx <= in_mvx;
      s1_my <= in_mvy;
      for (int k = 0; k < NBLK; k++)
        s1_blk[k] <= {{PAD{1'b0}}, in_sad4[k*SAD4_W +: SAD4_W]};
    end
  end

  for (genvar q = 0; q < 4; q++) begin : g_quad
    localparam int B = quad_corner(q);
    assign c_84[2*q]   = s1_blk[B]     + s1_blk[B+1];
    assign c_84[2*q+1] = s1_blk[B+4]   + s1_blk[B+5];
    assign c_48[2*q]   = s1_blk[B]     + s1_blk[B+4];
    assign c_48[2*q+1] = s1_blk[B+1]   + s1_blk[B+5];
    assign c_88[q]     = c_84[2*q] + c_84[2*q+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_f <= 1'b0; s2_l <= 1'b0;
      s2_mx <= '0; s2_my <= '0;
      for (int k = 0; k < NBLK; k++) s2_blk[k] <= '0;
      for (int k = 0; k < 8; k++) begin s2_84[k] <= '0; s2_48[k] <= '0; end
      for (int k = 0; k < 4; k++) s2_88[k] <= '0;
    end else begin
      s2_v <= s1_v; s2_f <= s1_f; s2_l <= s1_l;
      s2_mx <= s1_mx; s2_my <= s1_my;
      for (int k = 0; k < NBLK; k++) s2_blk[k] <= s1_blk[k];
      for (int k = 0; k < 8; k++) begin s2_84[k] <= c_84[k]; s2_48[k] <= c_48[k]; end
      for (int k = 0; k < 4; k++) s2_88[k] <= c_88[k];
    end
  end

  assign c_top  = add16(s2_88[0], s2_88[1]);
  assign c_bot  = add16(s2_88[2], s2_88[3]);
  assign c_lft  = add16(s2_88[0], s2_88[2]);
  assign c_rgt  = add16(s2_88[1], s2_88[3]);
  assign c_full = add16(c_top, c_bot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_v <= 1'b0; s3_f <= 1'b0; s3_l <= 1'b0;
      s3_mx <= '0; s3_my <= '0;
      for (int p = 0; p < NPART; p++) s3_sum[p] <= '0;
    end else begin
      s3_v <= s2_v; s3_f <= s2_f; s3_l <= s2_l;
      s3_mx <= s2_mx; s3_my <= s2_my;
      s3_sum[P_FULL]    <= c_full;
      s3_sum[P_HALFH]   <= c_top;
      s3_sum[P_HALFH+1] <= c_bot;
      s3_sum[P_HALFV]   <= c_lft;
      s3_sum[P_HALFV+1] <= c_rgt;
      for (int q = 0; q < 4; q++) s3_sum[P_QUAD+q] <= s2_88[q];
      for (int k = 0; k < 8; k++) begin
        s3_sum[P_8X4+k] <= s2_84[k];
        s3_sum[P_4X8+k] <= s2_48[k];
      end
      for (int k = 0; k < NBLK; k++) s3_sum[P_4X4+k] <= s2_blk[k];
    end
  end

  assign out_valid = s3_v;
  assign out_first = s3_f;
  assign out_last  = s3_l;
  assign out_mvx   = s3_mx;
  assign out_mvy   = s3_my;
  for (genvar p = 0; p < NPART; p++) begin : g_pack
    assign out_sum[p*SUM_W +: SUM_W] = s3_sum[p];
  end
endmodule

// File: rtl/vbs_min_track.sv
module vbs_min_track #(
  parameter int SUM_W = 16,
  parameter int MV_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             first,
  input  logic [SUM_W-1:0] sum,
  input  logic [MV_W-1:0]  mvx,
  input  logic [MV_W-1:0]  mvy,
  output logic [SUM_W-1:0] best_sad,
  output logic [MV_W-1:0]  best_mvx,
  output logic [MV_W-1:0]  best_mvy
);
  logic take;
  assign take = valid && (first || (sum < best_sad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_sad <= '0;
      best_mvx <= '0;
      best_mvy <= '0;
    end else if (take) begin
      best_sad <= sum;
      best_mvx <= mvx;
      best_mvy <= mvy;
    end
  end
endmodule

// File: rtl/vbs_sad_merge.sv
module vbs_sad_merge
  import vbs_pkg::*;
#(
  parameter int SAD4_W = 12,
  parameter int MV_W   = 6,
  parameter int SUM_W  = SAD4_W + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic [MV_W-1:0]         in_mvx,
  input  logic [MV_W-1:0]         in_mvy,
  input  logic [NBLK*SAD4_W-1:0]  in_sad4,
  output logic                    done,
  output logic [NPART*SUM_W-1:0]  best_sad,
  output logic [NPART*MV_W-1:0]   best_mvx,
  output logic [NPART*MV_W-1:0]   best_mvy
);
  logic                   first_pend;
  logic                   in_first;
  logic                   trk_valid, trk_first, trk_last;
  logic [MV_W-1:0]        trk_mvx, trk_mvy;
  logic [NPART*SUM_W-1:0] part_sum;

  // named views for the checker
  logic [SUM_W-1:0] w_sum_full, w_sum_lft, w_sum_rgt;
  assign w_sum_full = part_sum[P_FULL*SUM_W +: SUM_W];
  assign w_sum_lft  = part_sum[P_HALFV*SUM_W +: SUM_W];
  assign w_sum_rgt  = part_sum[(P_HALFV+1)*SUM_W +: SUM_W];

  assign in_first = start | first_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        first_pend <= 1'b0;
    else if (in_valid) first_pend <= 1'b0;
    else if (start)    first_pend <= 1'b1;
  end

  vbs_tree #(.SAD4_W(SAD4_W), .MV_W(MV_W), .SUM_W(SUM_W)) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_first (in_first),
    .in_last  (in_last),
    .in_mvx   (in_mvx),
    .in_mvy   (in_mvy),
    .in_sad4  (in_sad4),
    .out_valid(trk_valid),
    .out_first(trk_first),
    .out_last (trk_last),
    .out_mvx  (trk_mvx),
    .out_mvy  (trk_mvy),
    .out_sum  (part_sum)
  );

  for (genvar p = 0; p < NPART; p++) begin : g_trk
    vbs_min_track #(.SUM_W(SUM_W), .MV_W(MV_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (trk_valid),
      .first   (trk_first),
      .sum     (part_sum[p*SUM_W +: SUM_W]),
      .mvx     (trk_mvx),
      .mvy     (trk_mvy),
      .best_sad(best_sad[p*SUM_W +: SUM_W]),
      .best_mvx(best_mvx[p*MV_W +: MV_W]),
      .best_mvy(best_mvy[p*MV_W +: MV_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= trk_valid & trk_last;
  end
endmodule

// File: rtl/vbs_sad_merge_chk.sv
module vbs_sad_merge_chk #(
  parameter int SUM_W = 16,
  parameter int MV_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trk_valid,
  input logic             trk_first,
  input logic [SUM_W-1:0] w_sum_full,
  input logic [SUM_W-1:0] w_sum_lft,
  input logic [SUM_W-1:0] w_sum_rgt,
  input logic [SUM_W-1:0] best0_sad,
  input logic [MV_W-1:0]  best0_mvx,
  input logic [MV_W-1:0]  best0_mvy
);
  logic [SUM_W:0] lr_total;
  assign lr_total = {1'b0, w_sum_lft} + {1'b0, w_sum_rgt};

  AST_FULL_EQ_COLUMNS: assert property (@(posedge clk) disable iff (!rst_n)
    trk_valid |-> ({1'b0, w_sum_full} == lr_total)); // R2

  AST_FIRST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && trk_first) |=> (best0_sad == $past(w_sum_full))); // R8

  AST_MIN_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !trk_first) |=> (best0_sad <= $past(best0_sad))); // R2

  AST_TIE_KEEPS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !trk_first && (w_sum_full >= best0_sad))
      |=> ($stable(best0_mvx) && $stable(best0_mvy))); // R7
endmodule

bind vbs_sad_merge vbs_sad_merge_chk #(.SUM_W(SUM_W), .MV_W(MV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trk_valid (trk_valid),
  .trk_first (trk_first),
  .w_sum_full(w_sum_full),
  .w_sum_lft (w_sum_lft),
  .w_sum_rgt (w_sum_rgt),
  .best0_sad (best_sad[SUM_W-1:0]),
  .best0_mvx (best_mvx[MV_W-1:0]),
  .best0_mvy (best_mvy[MV_W-1:0])
);

// File: tb/vbs_sad_merge_bench.sv
module vbs_sad_merge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 41;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_last = 1'b0;
  logic [5:0]   in_mvx = '0;
  logic [5:0]   in_mvy = '0;
  logic [191:0] in_sad4 = '0;
  logic         done;
  logic [NP*16-1:0] best_sad;
  logic [NP*6-1:0]  best_mvx;
  logic [NP*6-1:0]  best_mvy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int         exp_sad [NP];
  logic [5:0] exp_mx  [NP];
  logic [5:0] exp_my  [NP];
  int         blk     [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  vbs_sad_merge u_vbs_sad_merge (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_last(in_last), .in_mvx(in_mvx), .in_mvy(in_mvy), .in_sad4(in_sad4),
    .done(done), .best_sad(best_sad), .best_mvx(best_mvx), .best_mvy(best_mvy)
  );

  // partition geometry in sub-block units: x, y, width, height
  function automatic void geom(input int p, output int x, output int y,
                               output int w, output int h);
    int j, q;
    if (p == 0) begin x = 0; y = 0; w = 4; h = 4; end
    else if (p <= 2) begin x = 0; y = (p-1)*2; w = 4; h = 2; end
    else if (p <= 4) begin x = (p-3)*2; y = 0; w = 2; h = 4; end
    else if (p <= 8) begin q = p-5; x = 2*(q%2); y = 2*(q/2); w = 2; h = 2; end
    else if (p <= 16) begin
      j = p-9; q = j/2; x = 2*(q%2); y = 2*(q/2) + j%2; w = 2; h = 1;
    end else if (p <= 24) begin
      j = p-17; q = j/2; x = 2*(q%2) + j%2; y = 2*(q/2); w = 1; h = 2;
    end else begin j = p-25; x = j%4; y = j/4; w = 1; h = 1; end
  endfunction

  function automatic int part_total(input int p);
    int x, y, w, h, s;
    geom(p, x, y, w, h);
    s = 0;
    for (int r = y; r < y+h; r++)
      for (int c = x; c < x+w; c++)
        s += blk[r*4+c];
    return s;
  endfunction

  function automatic string req_of(input int p);
    if (p == 0) return "R2";
    if (p <= 4) return "R3";
    if (p <= 8) return "R4";
    if (p <= 24) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_results(input string tag);
    string t;
    int a, e;
    for (int p = 0; p < NP; p++) begin
      t = (tag == "") ? req_of(p) : tag;
      checks++;
      a = {best_sad[p*16 +: 16]};
      e = exp_sad[p];
      if (a != e || best_mvx[p*6 +: 6] != exp_mx[p] || best_mvy[p*6 +: 6] != exp_my[p]) begin
        errors++;
        $display("FAIL %s R11 part %0d actual sad=%0d mv=(%0d,%0d) expected sad=%0d mv=(%0d,%0d)",
                 t, p, a, best_mvx[p*6 +: 6], best_mvy[p*6 +: 6], e, exp_mx[p], exp_my[p]);
      end
    end
  endtask

  // mode 0: full random, 1: constant 7, 2: values 0..3, 3: all 4095, 4: decreasing
  task automatic run_pass(input int n, input int mode, input string tag);
    int s, row, col;
    int dseen [4];
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < 16; k++) begin
        case (mode)
          0: blk[k] = int'($urandom_range(4095, 0));
          1: blk[k] = 7;
          2: blk[k] = int'($urandom_range(3, 0));
          3: blk[k] = 4095;
          default: blk[k] = (4095 - i - k) & 4095;
        endcase
        in_sad4[k*12 +: 12] = blk[k][11:0];
      end
      row = i / 64; col = i % 64;
      in_mvx   = 6'(col - 32);
      in_mvy   = 6'(row - 32);
      in_valid = 1'b1;
      in_last  = (i == n-1);
      for (int p = 0; p < NP; p++) begin
        s = part_total(p);
        if (i == 0 || s < exp_sad[p]) begin
          exp_sad[p] = s; exp_mx[p] = in_mvx; exp_my[p] = in_mvy;
        end
      end
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      dseen[k] = int'(done);
    end
    check("R10", dseen[0] + dseen[1] + dseen[2], 0, "done early");
    check("R10", dseen[3], 1, "done at fourth edge");
    check_results(tag);
    @(negedge clk);
    check("R10", int'(done), 0, "done single cycle");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", int'(done), 0, "done after reset");
    check("R1", int'(best_sad == '0), 1, "sad zero after reset");
    check("R1", int'(best_mvx == '0 && best_mvy == '0), 1, "mv zero after reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_pass(4096, 0, "");       // R9 full continuous raster pass
    run_pass(4096, 0, "R9");
    run_pass(100, 1, "R7");      // constant: all ties keep (-32,-32)
    check("R7", int'(best_mvx[5:0] == 6'h20 && best_mvy[5:0] == 6'h20), 1, "tie keeps first vector");
    run_pass(300, 2, "R7");
    run_pass(5, 3, "R8");        // larger than previous pass, and widest sum
    check("R8", int'(best_sad[15:0]), 65520, "first load and max full sum");
    run_pass(200, 4, "R11");
    run_pass(1, 0, "R8");        // single candidate pass
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule